// File: doc/BRIEF.md
# Wrapping Completion Event Counter

This block is the per-channel status register of a list-driven DMA engine. It tallies the load and completion events that the list fetcher raises, as single-cycle pulses, in a six-bit count that only hardware advances. Software acknowledges events by writing a six-bit "handled" count back into a separate field of the same register. It also writes zero to an interrupt-active flag. The number of unhandled events is the hardware count minus the handled count, taken modulo 64. Software works this out. The block does not compute it.

The flag drives a single active-high interrupt line. The channel's configuration word selects how that line behaves. When interrupts are allowed, the line can follow the flag as a level or emit a one-cycle pulse each time the flag rises. An event that lands in the same cycle as the acknowledge write is still counted. If the two counts differ after the write, the flag comes straight back, so no completion is lost. A channel cancel clears all three fields.

Top module: `evctr_chan_status`

## Requirements
- R1: While `rst` is high at a clock edge, the done count, the handled count and the active flag are cleared, and `irq` is low.
- R2: Each clock edge with `evt_pulse` high and `cancel` low adds one to the done count. The count wraps from 63 to 0.
- R3: A write (`wr_en` high) loads the handled count from `wr_data[21:16]`. A write never changes the done count, and an event in the same cycle as a write still adds one.
- R4: The active flag is set by an event only when both `cfg_word[29]` (interrupt allow) and `cfg_word[31]` (list interrupt allow) are 1. Otherwise an event leaves it as it was.
- R5: A write with `wr_data[8]` = 0 clears the active flag. A write with `wr_data[8]` = 1 keeps it. In either case the flag is 1 after the write if both allow bits are 1 and the done count after that edge differs from the handled count just written.
- R6: With `cfg_word[28]` = 1, `irq` equals the active flag. With `cfg_word[28]` = 0, `irq` is high for exactly the one cycle in which the flag goes from 0 to 1.
- R7: `cancel` clears the done count, the handled count and the active flag, and it takes priority over a coincident event or write.
- R8: The register word `rd_data` holds the done count in bits 5:0, the active flag in bit 8 and the handled count in bits 21:16. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 1 | One event from the list fetcher per high cycle |
| cancel | input | 1 | Channel cancel; clears all fields |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write word |
| cfg_word | input | 32 | Channel configuration word (bits 31, 29, 28 used) |
| rd_data | output | 32 | Current register word |
| irq | output | 1 | Active-high interrupt line |

## Verification
The hardest case is an event that arrives in exactly the cycle of an acknowledge write. It gets only harder when that write copies the pre-event count, so the done count moves past the value just written. The bench drives the event pulse and the write in the same cycle with interrupts allowed, and expects the flag and a level-mode `irq` to stay up. It also forces the done count through its 63-to-0 wrap and then acknowledges across that boundary. Pulse mode is tested with the flag first cleared, so a fresh rising edge can be seen.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
  parameter int REG_W = 32;
  parameter int CNT_W = 6;
  // Field positions decoded by software and by the configuration word owner.
  localparam int DONE_LSB     = 0;
  localparam int ACT_BIT      = 8;
  localparam int PROC_LSB     = 16;
  localparam int CFG_LEVEL    = 28;
  localparam int CFG_IEN      = 29;
  localparam int CFG_LIST_IEN = 31;
endpackage

// File: rtl/evctr_wrap_cnt.sv
module evctr_wrap_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt
);
  always_comb begin
    if (clr)      cnt_nxt = '0;
    else if (inc) cnt_nxt = cnt + W'(1);
    else          cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end
endmodule

// File: rtl/evctr_ack_reg.sv
module evctr_ack_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] val,
  output logic [W-1:0] val_nxt
);
  always_comb begin
    if (clr)       val_nxt = '0;
    else if (load) val_nxt = din;
    else           val_nxt = val;
  end

  always_ff @(posedge clk) begin
    if (rst) val <= '0;
    else     val <= val_nxt;
  end
endmodule

// File: rtl/evctr_irq_ctl.sv
module evctr_irq_ctl #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         allow,
  input  logic         level,
  input  logic         evt,
  input  logic         wr,
  input  logic         keep,
  input  logic [W-1:0] done_nxt,
  input  logic [W-1:0] proc_nxt,
  output logic         act,
  output logic         irq
);
  logic act_nxt;
  logic behind;

  assign behind = (done_nxt != proc_nxt);

  always_comb begin
    if (clr)     act_nxt = 1'b0;
    else if (wr) act_nxt = (keep & act) | (allow & behind);
    else         act_nxt = act | (allow & evt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      irq <= 1'b0;
    end else begin
      act <= act_nxt;
      irq <= level ? act_nxt : (act_nxt & ~act);
    end
  end
endmodule

// File: rtl/evctr_chan_status.sv
module evctr_chan_status #(
  parameter int REG_W = evctr_pkg::REG_W,
  parameter int CNT_W = evctr_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_pulse,
  input  logic             cancel,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] cfg_word,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  import evctr_pkg::*;

  logic [CNT_W-1:0] done_q, done_nxt;
  logic [CNT_W-1:0] proc_q, proc_nxt;
  logic             act_q;
  logic             allow;

  assign allow = cfg_word[CFG_IEN] & cfg_word[CFG_LIST_IEN];

  evctr_wrap_cnt #(.W(CNT_W)) u_done (
    .clk(clk), .rst(rst), .clr(cancel), .inc(evt_pulse),
    .cnt(done_q), .cnt_nxt(done_nxt)
  );

  evctr_ack_reg #(.W(CNT_W)) u_proc (
    .clk(clk), .rst(rst), .clr(cancel), .load(wr_en),
    .din(wr_data[PROC_LSB +: CNT_W]),
    .val(proc_q), .val_nxt(proc_nxt)
  );

  evctr_irq_ctl #(.W(CNT_W)) u_irq (
    .clk(clk), .rst(rst), .clr(cancel), .allow(allow),
    .level(cfg_word[CFG_LEVEL]), .evt(evt_pulse), .wr(wr_en),
    .keep(wr_data[ACT_BIT]), .done_nxt(done_nxt), .proc_nxt(proc_nxt),
    .act(act_q), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    rd_data[DONE_LSB +: CNT_W] = done_q;
    rd_data[ACT_BIT]           = act_q;
    rd_data[PROC_LSB +: CNT_W] = proc_q;
  end
endmodule

// File: rtl/evctr_chan_status_chk.sv
module evctr_chan_status_chk #(
  parameter int REG_W = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_pulse,
  input logic             cancel,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] cfg_word,
  input logic [CNT_W-1:0] done_q,
  input logic [CNT_W-1:0] proc_q,
  input logic             act_q,
  input logic             irq
);
  a_r2_done_step: assert property (@(posedge clk) disable iff (rst)
    (!cancel && evt_pulse) |=> done_q == CNT_W'($past(done_q) + 1));

  a_r3_write_keeps_done: assert property (@(posedge clk) disable iff (rst)
    (!cancel && !evt_pulse && wr_en) |=> $stable(done_q));

  a_r3_proc_load: assert property (@(posedge clk) disable iff (rst)
    (!cancel && wr_en) |=> proc_q == $past(wr_data[evctr_pkg::PROC_LSB +: CNT_W]));

  a_r4_event_sets: assert property (@(posedge clk) disable iff (rst)
    (!cancel && !wr_en && evt_pulse && cfg_word[evctr_pkg::CFG_IEN]
     && cfg_word[evctr_pkg::CFG_LIST_IEN]) |=> act_q);

  a_r6_level_follows: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_word[evctr_pkg::CFG_LEVEL]) |-> (irq == act_q));

  a_r6_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_word[evctr_pkg::CFG_LEVEL]) && irq) |-> $rose(act_q));

  a_r7_cancel_clears: assert property (@(posedge clk) disable iff (rst)
    cancel |=> (done_q == '0 && proc_q == '0 && !act_q));
endmodule

bind evctr_chan_status evctr_chan_status_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .cancel(cancel), .wr_en(wr_en),
  .wr_data(wr_data), .cfg_word(cfg_word), .done_q(done_q), .proc_q(proc_q),
  .act_q(act_q), .irq(irq)
);

// File: tb/evctr_chan_status_tb_top.sv
module evctr_chan_status_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_pulse = 1'b0;
  logic        cancel = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] cfg_word = '0;
  logic [31:0] rd_data;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  int m_done = 0, m_proc = 0, m_act = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evctr_chan_status dut_i (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .cancel(cancel),
    .wr_en(wr_en), .wr_data(wr_data), .cfg_word(cfg_word),
    .rd_data(rd_data), .irq(irq)
  );

  localparam logic [31:0] CFG_LVL   = 32'hB000_0000; // bits 31,29,28
  localparam logic [31:0] CFG_PULSE = 32'hA000_0000; // bits 31,29
  localparam logic [31:0] CFG_NOLST = 32'h3000_0000; // bit 31 off

  task automatic cyc(input bit e, input bit w, input bit c,
                     input logic [31:0] wd, input string tag);
    int nd, np, na, en;
    @(negedge clk);
    evt_pulse = e; wr_en = w; cancel = c; wr_data = wd;
    @(posedge clk);
    if (rst || c) begin
      m_done = 0; m_proc = 0; m_act = 0; m_irq = 0;
    end else begin
      en = (cfg_word[29] && cfg_word[31]) ? 1 : 0;
      nd = e ? (m_done + 1) % 64 : m_done;
      np = w ? int'(wd[21:16]) : m_proc;
      if (w) na = ((wd[8] && m_act != 0) || (en != 0 && nd != np)) ? 1 : 0;
      else   na = (m_act != 0 || (e && en != 0)) ? 1 : 0;
      m_irq = cfg_word[28] ? na : ((na != 0 && m_act == 0) ? 1 : 0);
      m_done = nd; m_proc = np; m_act = na;
    end
    #1;
    begin
      logic [31:0] exp_rd;
      exp_rd = (32'(m_proc) << 16) | (32'(m_act) << 8) | 32'(m_done);
      compared++;
      if (rd_data !== exp_rd || irq !== m_irq[0]) begin
        mismatched++;
        $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%0d",
                 tag, rd_data, irq, exp_rd, m_irq);
      end
    end
    evt_pulse = 0; wr_en = 0; cancel = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, '0, "R1");
    @(negedge clk); rst = 0;
    cyc(0, 0, 0, '0, "R1");
    // R2/R4: events with interrupts allowed, level mode (R6)
    cfg_word = CFG_LVL;
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, '0, "R2_R4");
    // R5: acknowledge catching up, flag clears
    cyc(0, 1, 0, 32'h0005_0000, "R5");
    cyc(0, 0, 0, '0, "R6");
    // R3/R5: event coincides with acknowledge of old count
    cyc(1, 1, 0, 32'h0005_0000, "R3_R5");
    // R5: keep bit set retains flag
    cyc(0, 1, 0, 32'h0006_0100, "R5");
    cyc(0, 1, 0, 32'h0006_0000, "R5");
    // R4: events without list interrupt allow
    cfg_word = CFG_NOLST;
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, '0, "R4");
    cfg_word = 32'h9000_0000;
    cyc(1, 0, 0, '0, "R4");
    // R5: write clears with interrupts off even though counts differ
    cyc(1, 1, 0, 32'h0001_0000, "R5");
    // R2: wrap the done count
    cfg_word = CFG_LVL;
    for (int i = 0; i < 70; i++) cyc(1, 0, 0, '0, "R2");
    cyc(0, 1, 0, 32'h003F_0000, "R3_R5");
    cyc(0, 1, 0, 32'h0000_0000, "R3_R5");
    // R6: pulse mode, flag cleared first then risen
    cfg_word = CFG_PULSE;
    cyc(0, 1, 0, {10'd0, 6'(m_done), 16'd0}, "R6");
    cyc(1, 0, 0, '0, "R6");
    cyc(0, 0, 0, '0, "R6");
    cyc(1, 0, 0, '0, "R6");
    cyc(1, 1, 0, 32'h0000_0000, "R6");
    cyc(0, 0, 0, '0, "R6");
    // R8: all-ones write, unused bits stay zero
    cfg_word = CFG_LVL;
    cyc(0, 1, 0, 32'hFFFF_FFFF, "R8");
    cyc(0, 0, 0, '0, "R8");
    // R7: cancel beats event and write
    cyc(1, 1, 1, 32'h0015_0100, "R7");
    cyc(0, 0, 0, '0, "R7");
    cyc(1, 0, 0, '0, "R7");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule